// File: doc/BRIEF.md
# Power supply supervisor timing controller

This block is the digital timing and protection core of a desktop power supply supervisor. Analog comparators outside it turn rail voltages into flags. It receives an over-voltage flag and an under-voltage flag for each monitored rail, two flags for the power-good input (one for the lower 0.95 V threshold, one for the upper 1.2 V threshold), and an active-low request that turns the supply on. It drives two logic levels, each meant for an open-drain pin: a latched fault output and a power-good output.

Each flag is synchronised and then filtered with a time that depends on the signal. An over-voltage must persist 55 µs. The power-good-input flags and the under-voltage flags must persist 73 µs. The on/off request must persist 38 ms. A filtered under-voltage must then last a further 75 ms before it counts as a fault, and it is ignored entirely while the power-good input is below its lower threshold. A qualifying fault latches the fault output high and drops power-good. Power-good rises 300 ms after its conditions are met. Releasing the on/off request, once debounced, clears the latch, and 2.4 ms later it forces the fault output high. All delays are cycle counts derived from `CLK_HZ` and per-delay time parameters in microseconds.

Top module: `pss_supervisor`

## Requirements
- R1: An over-voltage flag on any rail counts as a fault only after its synchronised level has been high for OV_US worth of cycles without a break. A shorter pulse has no effect on either output.
- R2: The power-good-input flags and every under-voltage flag are ignored until they have held a new level for GLITCH_US worth of cycles. A shorter pulse on the upper power-good-input flag does not drop power-good.
- R3: A change on `on_req_ni` is acted on only after the new level has held for DEBOUNCE_US worth of cycles. A shorter release leaves a latched fault high.
- R4: A filtered under-voltage, with under-voltage detection enabled, sets the fault only after it has persisted UV_HOLD_US worth of cycles.
- R5: While the filtered lower power-good-input flag is 0, under-voltage never sets the fault. Over-voltage still does.
- R6: Once set, the fault latch holds `fault_o` high after the fault flags clear, until the on/off request is released. `pg_o` is low in every cycle in which the latch is set.
- R7: `pg_o` is 1 only when the debounced `on_req_ni` is 0, the filtered upper power-good-input flag is 1 and no fault is latched. It rises PG_HOLD_US worth of cycles after these conditions start to hold.
- R8: A debounced high on `on_req_ni` clears the fault latch and forces `pg_o` low. `fault_o` goes high after the high level has lasted a further OFF_HOLD_US worth of cycles, and goes low again when the debounced request returns low.
- R9: Every filter and timer restarts from zero when its qualifying condition drops, so an interrupted power-good condition waits a full PG_HOLD_US again.
- R10: While `rst_ni` is low, all filters, timers and the latch are cleared, and `pg_o` and `fault_o` are 0.
- R11: Each input passes through two synchroniser flops. A held over-voltage input with OV cycles = 6 sets `fault_o` at the 9th rising edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ov_i | input | N_RAILS | Over-voltage flag per rail, 1 = over |
| uv_i | input | N_RAILS | Under-voltage flag per rail, 1 = under |
| pgi_lo_i | input | 1 | 1 = power-good input above its lower (0.95 V) threshold |
| pgi_hi_i | input | 1 | 1 = power-good input above its upper (1.2 V) threshold |
| on_req_ni | input | 1 | Supply on request, 0 = on, 1 = off |
| fault_o | output | 1 | Fault protection level, 1 = fault/off |
| pg_o | output | 1 | Power-good level, 1 = good |

## Verification
On every cycle, the assertions check that a filter output only moves to a level its synchroniser has already shown, and that a timer completes only after its condition was present. They also check that the latch sets only from an over-voltage or a completed under-voltage fault, that it holds until a debounced off request, and that while the lower power-good-input flag is 0 it sets only from over-voltage. Finally, they check that power-good is never high together with the fault output. The exact lengths of the filter and delay windows can only be shown by the bench's scenarios: rejected short pulses, a restarted power-good delay, the low gap in the fault output between the latch clearing and the off delay expiring, and the synchroniser latency.

// File: rtl/pss_pkg.sv
package pss_pkg;
  // microseconds to clock cycles, at least one cycle
  function automatic int unsigned us_to_cyc(longint unsigned clk_hz, longint unsigned us);
    longint unsigned c;
    c = (clk_hz * us) / 64'd1_000_000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction
endpackage

// File: rtl/pss_sync_filter.sv
module pss_sync_filter #(
  parameter int unsigned CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned W = $clog2(CYC + 1);

  logic [1:0]   sync_q;
  logic [W-1:0] cnt_q;
  logic         q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
      q_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], d_i};
      if (sync_q[1] == q_q) begin
        cnt_q <= '0;
      end else if (cnt_q == W'(CYC - 1)) begin
        q_q   <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign q_o = q_q;

  // filtered level only moves to what the synchroniser presented (R1, R3)
  assert_filter_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_q) |-> ($past(sync_q[1]) == q_q));
endmodule

// File: rtl/pss_hold_timer.sv
module pss_hold_timer #(
  parameter int unsigned CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(CYC + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!cond_i)            cnt_q <= '0;
    else if (cnt_q != W'(CYC))   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = cond_i && (cnt_q == W'(CYC));

  assert_done_needs_cond_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cond_i));
endmodule

// File: rtl/pss_supervisor.sv
module pss_supervisor #(
  parameter int unsigned N_RAILS     = 3,
  parameter int unsigned CLK_HZ      = 25_000_000,
  parameter int unsigned OV_US       = 55,
  parameter int unsigned GLITCH_US   = 73,
  parameter int unsigned DEBOUNCE_US = 38_000,
  parameter int unsigned UV_HOLD_US  = 75_000,
  parameter int unsigned PG_HOLD_US  = 300_000,
  parameter int unsigned OFF_HOLD_US = 2_400
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_RAILS-1:0] ov_i,
  input  logic [N_RAILS-1:0] uv_i,
  input  logic               pgi_lo_i,
  input  logic               pgi_hi_i,
  input  logic               on_req_ni,
  output logic               fault_o,
  output logic               pg_o
);
  import pss_pkg::*;

  localparam int unsigned OV_CYC  = us_to_cyc(CLK_HZ, OV_US);
  localparam int unsigned GL_CYC  = us_to_cyc(CLK_HZ, GLITCH_US);
  localparam int unsigned DB_CYC  = us_to_cyc(CLK_HZ, DEBOUNCE_US);
  localparam int unsigned UV_CYC  = us_to_cyc(CLK_HZ, UV_HOLD_US);
  localparam int unsigned PG_CYC  = us_to_cyc(CLK_HZ, PG_HOLD_US);
  localparam int unsigned OFF_CYC = us_to_cyc(CLK_HZ, OFF_HOLD_US);

  logic [N_RAILS-1:0] ov_f, uv_f;
  logic pgi_lo_f, pgi_hi_f, off_f;
  logic ov_any, uv_cond, uv_fault, off_done, pg_cond, pg_done;
  logic fault_q;

  for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
    pss_sync_filter #(.CYC(OV_CYC)) i_ov_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ov_i[r]), .q_o(ov_f[r]));
    pss_sync_filter #(.CYC(GL_CYC)) i_uv_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(uv_i[r]), .q_o(uv_f[r]));
  end

  pss_sync_filter #(.CYC(GL_CYC)) i_pgi_lo_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pgi_lo_i), .q_o(pgi_lo_f));
  pss_sync_filter #(.CYC(GL_CYC)) i_pgi_hi_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pgi_hi_i), .q_o(pgi_hi_f));
  pss_sync_filter #(.CYC(DB_CYC)) i_on_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(on_req_ni), .q_o(off_f));

  assign ov_any  = |ov_f;
  // under-voltage counts only above the lower power-good threshold
  assign uv_cond = (|uv_f) && pgi_lo_f;

  pss_hold_timer #(.CYC(UV_CYC)) i_uv_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(uv_cond), .done_o(uv_fault));
  pss_hold_timer #(.CYC(OFF_CYC)) i_off_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(off_f), .done_o(off_done));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 fault_q <= 1'b0;
    else if (off_f)              fault_q <= 1'b0;
    else if (ov_any || uv_fault) fault_q <= 1'b1;
  end

  assign pg_cond = !off_f && pgi_hi_f && !fault_q;

  pss_hold_timer #(.CYC(PG_CYC)) i_pg_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(pg_cond), .done_o(pg_done));

  assign pg_o    = pg_done;
  assign fault_o = fault_q || off_done;

  assert_latch_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(ov_any || uv_fault));
  assert_latch_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !off_f) |=> fault_q);
  assert_uv_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fault_q) && !$past(pgi_lo_f)) |-> $past(ov_any));
  assert_off_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_f |=> !fault_q);
  assert_pg_excl_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pg_o && fault_o));
endmodule

// File: tb/test_pss_supervisor.sv
module test_pss_supervisor;
  localparam int NR  = 3;
  localparam int OVC = 6, GLC = 8, DBC = 40, UVC = 100, PGC = 300, OFC = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] ov = '0, uv = '0;
  logic pgi_lo = 1'b1, pgi_hi = 1'b1, on_req_n = 1'b0;
  logic fault, pg;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  pss_supervisor #(
    .N_RAILS(NR), .CLK_HZ(1_000_000), .OV_US(OVC), .GLITCH_US(GLC),
    .DEBOUNCE_US(DBC), .UV_HOLD_US(UVC), .PG_HOLD_US(PGC), .OFF_HOLD_US(OFC)
  ) i_pss_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .ov_i(ov), .uv_i(uv), .pgi_lo_i(pgi_lo),
    .pgi_hi_i(pgi_hi), .on_req_ni(on_req_n), .fault_o(fault), .pg_o(pg));

  // reference model: index 0..2 ov, 3..5 uv, 6 pgi_lo, 7 pgi_hi, 8 on_req_n
  int s1[9], s2[9], lvl[9], run[9], lim[9];
  int uv_t, off_t, pg_t, latch;
  int m_pg, m_fault;

  function automatic int any3(int a, int b, int c);
    return (a != 0 || b != 0 || c != 0) ? 1 : 0;
  endfunction

  always_comb begin
    int uvc, offd, pgc;
    uvc  = (any3(lvl[3], lvl[4], lvl[5]) != 0 && lvl[6] != 0) ? 1 : 0;
    offd = (lvl[8] != 0 && off_t == OFC) ? 1 : 0;
    pgc  = (lvl[8] == 0 && lvl[7] != 0 && latch == 0) ? 1 : 0;
    m_pg    = (pgc != 0 && pg_t == PGC) ? 1 : 0;
    m_fault = (latch != 0 || offd != 0) ? 1 : 0;
    if (uvc == 0) m_fault = m_fault;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) begin s1[i] = 0; s2[i] = 0; lvl[i] = 0; run[i] = 0; end
      uv_t = 0; off_t = 0; pg_t = 0; latch = 0;
    end else begin
      int ova, uvc, uvf, pgc, inp[9];
      ova = any3(lvl[0], lvl[1], lvl[2]);
      uvc = (any3(lvl[3], lvl[4], lvl[5]) != 0 && lvl[6] != 0) ? 1 : 0;
      uvf = (uvc != 0 && uv_t == UVC) ? 1 : 0;
      pgc = (lvl[8] == 0 && lvl[7] != 0 && latch == 0) ? 1 : 0;
      pg_t = (pgc != 0) ? ((pg_t < PGC) ? pg_t + 1 : PGC) : 0;
      if (lvl[8] != 0) latch = 0;
      else if (ova != 0 || uvf != 0) latch = 1;
      uv_t  = (uvc != 0) ? ((uv_t < UVC) ? uv_t + 1 : UVC) : 0;
      off_t = (lvl[8] != 0) ? ((off_t < OFC) ? off_t + 1 : OFC) : 0;
      for (int i = 0; i < 9; i++) begin
        if (s2[i] != lvl[i]) begin
          run[i]++;
          if (run[i] == lim[i]) begin lvl[i] = s2[i]; run[i] = 0; end
        end else run[i] = 0;
      end
      for (int i = 0; i < NR; i++) begin inp[i] = int'(ov[i]); inp[3+i] = int'(uv[i]); end
      inp[6] = int'(pgi_lo); inp[7] = int'(pgi_hi); inp[8] = int'(on_req_n);
      for (int i = 0; i < 9; i++) begin s2[i] = s1[i]; s1[i] = inp[i]; end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    checks++;
    if (int'(pg) != m_pg || int'(fault) != m_fault) begin
      errors++;
      $display("FAIL %s model: pg=%0b fault=%0b expected pg=%0d fault=%0d at cycle %0d",
               cur_req, pg, fault, m_pg, m_fault, cycles);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50_000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 50000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 9; i++) lim[i] = GLC;
    for (int i = 0; i < NR; i++) lim[i] = OVC;
    lim[8] = DBC;

    step(5);
    chk("R10", "pg in reset", pg, 1'b0);
    chk("R10", "fault in reset", fault, 1'b0);
    rst_n = 1'b1;

    cur_req = "R7";
    step(250); chk("R7", "pg before delay", pg, 1'b0);
    step(80);  chk("R7", "pg after delay", pg, 1'b1);

    cur_req = "R1";
    ov[1] = 1'b1; step(5); ov[1] = 1'b0;
    step(30); chk("R1", "fault after short ov", fault, 1'b0);
    chk("R1", "pg after short ov", pg, 1'b1);
    ov[1] = 1'b1; step(6); ov[1] = 1'b0;
    step(30); chk("R1", "fault after full ov", fault, 1'b1);
    chk("R6", "pg with latch", pg, 1'b0);
    cur_req = "R6";
    step(100); chk("R6", "fault latched", fault, 1'b1);

    cur_req = "R3";
    on_req_n = 1'b1; step(20); on_req_n = 1'b0;
    step(60); chk("R3", "fault after short release", fault, 1'b1);
    cur_req = "R8";
    on_req_n = 1'b1;
    step(52); chk("R8", "fault in off gap", fault, 1'b0);
    chk("R8", "pg when off", pg, 1'b0);
    step(30); chk("R8", "fault forced by off", fault, 1'b1);
    on_req_n = 1'b0;
    step(60); chk("R8", "fault after on", fault, 1'b0);
    step(300); chk("R7", "pg after restart", pg, 1'b1);

    cur_req = "R9";
    pgi_hi = 1'b0; step(20); pgi_hi = 1'b1;
    step(250); chk("R9", "pg delay restarted", pg, 1'b0);
    step(80);  chk("R9", "pg after restarted delay", pg, 1'b1);
    cur_req = "R2";
    pgi_hi = 1'b0; step(5); pgi_hi = 1'b1;
    step(30); chk("R2", "pg after pgi glitch", pg, 1'b1);

    cur_req = "R4";
    uv[0] = 1'b1; step(50); uv[0] = 1'b0;
    step(200); chk("R4", "fault after short uv", fault, 1'b0);
    uv[2] = 1'b1;
    step(80);  chk("R4", "fault before uv hold", fault, 1'b0);
    step(70);  chk("R4", "fault after uv hold", fault, 1'b1);
    uv[2] = 1'b0;
    on_req_n = 1'b1; step(100); on_req_n = 1'b0; step(60);

    cur_req = "R5";
    pgi_lo = 1'b0; pgi_hi = 1'b0; step(30);
    uv[0] = 1'b1; step(300);
    chk("R5", "uv masked", fault, 1'b0);
    chk("R7", "pg with low pgi", pg, 1'b0);
    ov[0] = 1'b1; step(30);
    chk("R5", "ov in masked region", fault, 1'b1);
    ov[0] = 1'b0; uv[0] = 1'b0;
    on_req_n = 1'b1; step(100); on_req_n = 1'b0;
    pgi_lo = 1'b1; pgi_hi = 1'b1;
    step(420); chk("R7", "pg recovered", pg, 1'b1);

    cur_req = "R11";
    ov[2] = 1'b1;
    step(8); chk("R11", "fault at edge 8", fault, 1'b0);
    step(1); chk("R11", "fault at edge 9", fault, 1'b1);
    step(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule